// File: doc/BRIEF.md
# Parallel Flash Chip-Erase Sequencer

This block sits on the host side of a byte-wide parallel flash device and runs one complete chip erase for a requester. A single-cycle start pulse makes it issue the six-write erase command on the flash address/data/strobe bus. It then polls the device with read cycles until the status byte shows completion, a device-reported failure, or a host-side poll limit is reached.

The block reports the outcome through a one-cycle done pulse and three held result flags: pass, fail (the device flagged its internal time limit) and tmo (the host poll budget ran out). Before a fail or tmo result is signalled, the block writes the return-to-read command so the device is usable again. Bus writes hold address and data steady around a chip-enable/write-enable strobe of a parameterised length. Reads use chip-enable/output-enable and sample the data on the last strobe cycle.

Top module: `erase_ctrl`

## Requirements
- R1: A start pulse is accepted only while busy is low (idle, or the cycle in which done is high). busy rises the cycle after acceptance and stays high until the done cycle. A start pulse while busy is high has no effect on the bus traffic or on the result.
- R2: After acceptance the block performs exactly six bus writes, as (address, data): (555h, AAh), (2AAh, 55h), (555h, 80h), (555h, AAh), (2AAh, 55h), (555h, 10h).
- R3: Every write holds fl_ce_n and fl_we_n low together for exactly STROBE_CYC clocks. fl_addr and fl_dq_out stay constant from the first low cycle through the rising edge of fl_we_n. fl_oe_n is never low while fl_we_n is low or fl_dq_oe is high.
- R4: After the sixth write, the block issues only read cycles (fl_oe_n low, fl_we_n high) at address 0 until it reaches a verdict.
- R5: Status bits are Q7 = bit 7, Q6 = bit 6, Q5 = bit 5. A read with Q7 = 1 whose Q6 equals Q6 of the previous read in the same erase ends the erase with pass. The first poll read can never end it.
- R6: A read with Q5 = 1 that does not meet R5 is followed by exactly two more reads. The result is pass if both show Q7 = 1 and their Q6 values are equal, and fail otherwise.
- R7: If MAX_POLLS ordinary reads (reads that are not the follow-up reads of R6) reach neither R5 nor Q5 = 1, the result is tmo.
- R8: On fail or tmo, one write of F0h to address 0 is issued before done. On pass, no write follows the six command writes.
- R9: done is high for exactly one clock, with exactly one of pass, fail or tmo high. The flags keep their value until the next accepted start clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle erase request |
| busy | output | 1 | Erase in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Erase verified complete |
| fail | output | 1 | Device reported internal time limit exceeded |
| tmo | output | 1 | Host poll limit reached |
| fl_addr | output | AW | Flash address |
| fl_dq_out | output | 8 | Flash write data |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_dq_in | input | 8 | Flash read data |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
The properties assume that start is a clean synchronous pulse. They also assume that fl_dq_in only has to be valid while fl_oe_n and fl_ce_n are both low, so no check looks at read data outside a read strobe. The bench's flash model drives a scripted status byte only during such strobes and raises start only on falling clock edges. It advances its script once per completed read, which keeps the Q6 toggling pattern tied to real read cycles, as a device would.

// File: rtl/erase_pkg.sv
package erase_pkg;

    localparam int CMD_AW = 12;
    localparam int N_CMD  = 6;

    localparam logic [CMD_AW-1:0] UNLOCK_A  = 12'h555;
    localparam logic [CMD_AW-1:0] UNLOCK_B  = 12'h2AA;
    localparam logic [CMD_AW-1:0] POLL_ADDR = 12'h000;
    localparam logic [CMD_AW-1:0] ABORT_ADDR = 12'h000;
    localparam logic [7:0]        ABORT_CODE = 8'hF0;

    typedef enum logic { CYC_WR, CYC_RD } cyc_kind_e;

    typedef struct packed {
        cyc_kind_e         kind;
        logic [CMD_AW-1:0] addr;
        logic [7:0]        data;
    } cyc_req_t;

    typedef enum logic [1:0] { V_CONT, V_OK, V_BAD, V_WDOG } verdict_e;

    typedef enum logic [2:0] { S_IDLE, S_CMD, S_POLL, S_ABORT, S_FIN } seq_state_e;

    typedef enum logic [1:0] { B_IDLE, B_SETUP, B_STROBE, B_HOLD } bus_state_e;

    function automatic cyc_req_t cmd_step(input logic [2:0] idx);
        cyc_req_t r;
        r.kind = CYC_WR;
        case (idx)
            3'd0:    begin r.addr = UNLOCK_A; r.data = 8'hAA; end
            3'd1:    begin r.addr = UNLOCK_B; r.data = 8'h55; end
            3'd2:    begin r.addr = UNLOCK_A; r.data = 8'h80; end
            3'd3:    begin r.addr = UNLOCK_A; r.data = 8'hAA; end
            3'd4:    begin r.addr = UNLOCK_B; r.data = 8'h55; end
            default: begin r.addr = UNLOCK_A; r.data = 8'h10; end
        endcase
        return r;
    endfunction

    function automatic cyc_req_t poll_step();
        cyc_req_t r;
        r.kind = CYC_RD;
        r.addr = POLL_ADDR;
        r.data = 8'h00;
        return r;
    endfunction

    function automatic cyc_req_t abort_step();
        cyc_req_t r;
        r.kind = CYC_WR;
        r.addr = ABORT_ADDR;
        r.data = ABORT_CODE;
        return r;
    endfunction

endpackage

// File: rtl/erase_bus_cyc.sv
module erase_bus_cyc
    import erase_pkg::*;
#(
    parameter int AW         = 18,
    parameter int STROBE_CYC = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  cyc_req_t      req,
    output logic          ready,
    output logic          ack,
    output logic [7:0]    rdata,
    input  logic [7:0]    fl_dq_in,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dq_out,
    output logic          fl_dq_oe,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n
);
    localparam int CW = $clog2(STROBE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(STROBE_CYC - 1);

    bus_state_e     st;
    cyc_req_t       cur;
    logic [CW-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= B_IDLE;
            cur   <= '0;
            cnt   <= '0;
            rdata <= '0;
        end else begin
            case (st)
                B_IDLE: if (req_valid) begin
                    cur <= req;
                    st  <= B_SETUP;
                end
                B_SETUP: begin
                    cnt <= '0;
                    st  <= B_STROBE;
                end
                B_STROBE: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        st <= B_HOLD;
                        if (cur.kind == CYC_RD) rdata <= fl_dq_in;
                    end
                end
                default: st <= B_IDLE;
            endcase
        end
    end

    always_comb begin
        ready     = (st == B_IDLE);
        ack       = (st == B_HOLD);
        fl_addr   = {{(AW-CMD_AW){1'b0}}, cur.addr};
        fl_dq_out = cur.data;
        fl_dq_oe  = (st != B_IDLE) && (cur.kind == CYC_WR);
        fl_ce_n   = (st != B_STROBE);
        fl_we_n   = !((st == B_STROBE) && (cur.kind == CYC_WR));
        fl_oe_n   = !((st == B_STROBE) && (cur.kind == CYC_RD));
    end

endmodule

// File: rtl/erase_poll_eval.sv
module erase_poll_eval
    import erase_pkg::*;
#(
    parameter int MAX_POLLS = 4096
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       valid,
    input  logic [7:0] rdata,
    output verdict_e   verdict
);
    localparam int PW = $clog2(MAX_POLLS + 1);

    logic          prev_q6, have_prev;
    logic          retry_mode, retry_idx, first_q7;
    logic [PW-1:0] polls;

    logic q7, q6, q5, steady;

    always_comb begin
        q7     = rdata[7];
        q6     = rdata[6];
        q5     = rdata[5];
        steady = have_prev && (q6 == prev_q6);
        if (retry_mode) begin
            if (!retry_idx)                  verdict = V_CONT;
            else if (first_q7 && q7 && steady) verdict = V_OK;
            else                             verdict = V_BAD;
        end else if (q7 && steady)           verdict = V_OK;
        else if (q5)                         verdict = V_CONT;
        else if (polls == PW'(MAX_POLLS - 1)) verdict = V_WDOG;
        else                                 verdict = V_CONT;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            prev_q6    <= 1'b0;
            have_prev  <= 1'b0;
            retry_mode <= 1'b0;
            retry_idx  <= 1'b0;
            first_q7   <= 1'b0;
            polls      <= '0;
        end else if (valid) begin
            prev_q6   <= q6;
            have_prev <= 1'b1;
            if (retry_mode) begin
                retry_idx <= 1'b1;
                first_q7  <= q7;
            end else if (q5 && !(q7 && steady)) begin
                retry_mode <= 1'b1;
                retry_idx  <= 1'b0;
            end else begin
                polls <= polls + 1'b1;
            end
        end
    end

endmodule

// File: rtl/erase_ctrl.sv
module erase_ctrl
    import erase_pkg::*;
#(
    parameter int AW         = 18,
    parameter int STROBE_CYC = 3,
    parameter int MAX_POLLS  = 4096
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic          fail,
    output logic          tmo,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [7:0]    fl_dq_in,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n
);
    localparam logic [2:0] LAST_CMD = 3'(N_CMD - 1);

    seq_state_e st;
    logic [2:0] cmd_idx;
    logic       issued;
    cyc_req_t   req;
    logic       req_valid, eng_ready, eng_ack;
    logic [7:0] eng_rdata;
    verdict_e   verdict;
    logic       start_ok, ev_valid;

    always_comb begin
        start_ok  = start && (st == S_IDLE || st == S_FIN);
        ev_valid  = eng_ack && (st == S_POLL);
        req_valid = !issued && (st == S_CMD || st == S_POLL || st == S_ABORT);
        case (st)
            S_POLL:  req = poll_step();
            S_ABORT: req = abort_step();
            default: req = cmd_step(cmd_idx);
        endcase
        busy = (st == S_CMD) || (st == S_POLL) || (st == S_ABORT);
        done = (st == S_FIN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            cmd_idx <= '0;
            issued  <= 1'b0;
            pass    <= 1'b0;
            fail    <= 1'b0;
            tmo     <= 1'b0;
        end else begin
            if (req_valid && eng_ready) issued <= 1'b1;
            if (eng_ack)                issued <= 1'b0;
            case (st)
                S_IDLE, S_FIN: begin
                    if (start_ok) begin
                        st      <= S_CMD;
                        cmd_idx <= '0;
                        pass    <= 1'b0;
                        fail    <= 1'b0;
                        tmo     <= 1'b0;
                    end else begin
                        st <= S_IDLE;
                    end
                end
                S_CMD: if (eng_ack) begin
                    if (cmd_idx == LAST_CMD) st <= S_POLL;
                    else                     cmd_idx <= cmd_idx + 1'b1;
                end
                S_POLL: if (eng_ack) begin
                    case (verdict)
                        V_OK:   begin pass <= 1'b1; st <= S_FIN;   end
                        V_BAD:  begin fail <= 1'b1; st <= S_ABORT; end
                        V_WDOG: begin tmo  <= 1'b1; st <= S_ABORT; end
                        default: ;
                    endcase
                end
                S_ABORT: if (eng_ack) st <= S_FIN;
                default: st <= S_IDLE;
            endcase
        end
    end

    erase_bus_cyc #(.AW(AW), .STROBE_CYC(STROBE_CYC)) u_bus (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req       (req),
        .ready     (eng_ready),
        .ack       (eng_ack),
        .rdata     (eng_rdata),
        .fl_dq_in  (fl_dq_in),
        .fl_addr   (fl_addr),
        .fl_dq_out (fl_dq_out),
        .fl_dq_oe  (fl_dq_oe),
        .fl_ce_n   (fl_ce_n),
        .fl_we_n   (fl_we_n),
        .fl_oe_n   (fl_oe_n)
    );

    erase_poll_eval #(.MAX_POLLS(MAX_POLLS)) u_eval (
        .clk     (clk),
        .rst     (rst),
        .clear   (start_ok),
        .valid   (ev_valid),
        .rdata   (eng_rdata),
        .verdict (verdict)
    );

endmodule

// File: rtl/erase_ctrl_chk.sv
module erase_ctrl_chk #(
    parameter int AW = 18
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          pass,
    input logic          fail,
    input logic          tmo,
    input logic [AW-1:0] fl_addr,
    input logic [7:0]    fl_dq_out,
    input logic          fl_dq_oe,
    input logic          fl_ce_n,
    input logic          fl_we_n,
    input logic          fl_oe_n
);
    // R9: exactly one result flag with done
    a_r9_one_flag: assert property (@(posedge clk) disable iff (rst)
        done |-> ($countones({pass, fail, tmo}) == 1));

    // R9: done lasts one clock
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: flags hold while idle with no start
    a_r9_flags_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable({pass, fail, tmo}));

    // R1: busy only ends through done
    a_r1_busy_until_done: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy || done));

    // R1: done and busy never overlap
    a_r1_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R3: write strobe only with chip enable
    a_r3_we_with_ce: assert property (@(posedge clk) disable iff (rst)
        !fl_we_n |-> !fl_ce_n);

    // R3: no read strobe during write or while driving data
    a_r3_no_contention: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> (fl_we_n && !fl_dq_oe));

    // R3: address and data steady during the write strobe
    a_r3_write_stable: assert property (@(posedge clk) disable iff (rst)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));

    // R3: address and data still steady on the strobe's rising edge
    a_r3_write_release: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_dq_out)));

    // R4: polls read address zero
    a_r4_read_addr: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> (fl_addr == '0));
endmodule

bind erase_ctrl erase_ctrl_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .pass      (pass),
    .fail      (fail),
    .tmo       (tmo),
    .fl_addr   (fl_addr),
    .fl_dq_out (fl_dq_out),
    .fl_dq_oe  (fl_dq_oe),
    .fl_ce_n   (fl_ce_n),
    .fl_we_n   (fl_we_n),
    .fl_oe_n   (fl_oe_n)
);

// File: tb/erase_ctrl_tb.sv
`timescale 1ns/1ps
module erase_ctrl_tb;
    localparam int AW = 18;
    localparam int SC = 2;
    localparam int MP = 12;
    localparam int LIMIT = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy, done, pass, fail, tmo;
    logic [AW-1:0] fl_addr;
    logic [7:0] fl_dq_out, fl_dq_in;
    logic fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;

    always #2 clk = ~clk;

    erase_ctrl #(.AW(AW), .STROBE_CYC(SC), .MAX_POLLS(MP)) u_dut (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .pass(pass), .fail(fail), .tmo(tmo), .fl_addr(fl_addr),
        .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scripted flash status
    int sc_busy = 0;
    int sc_q5 = -1;
    int rd_idx = 0;
    int rd_base = 0;

    function automatic logic [7:0] stat(input int nb, input int q5at, input int k);
        logic [7:0] s;
        if (k < nb) begin
            s = 8'h00;
            s[6] = k[0];
            s[5] = (q5at >= 0) && (k >= q5at);
        end else begin
            s = 8'hFF;
        end
        return s;
    endfunction

    always_comb fl_dq_in = (!fl_ce_n && !fl_oe_n) ? stat(sc_busy, sc_q5, rd_idx - rd_base) : 8'h00;

    // behavioural busy model, compared each clock
    logic mb = 1'b0;
    always @(posedge clk) begin
        if (rst) mb <= 1'b0;
        else if (start && (!mb || done)) mb <= 1'b1;
        else if (done) mb <= 1'b0;
    end

    // bus monitor
    logic [AW+7:0] wr_q[$];
    int we_len = 0;
    logic prev_we = 1'b1;
    logic prev_oe = 1'b1;
    logic [AW-1:0] cap_a;
    logic [7:0] cap_d;

    always @(negedge clk) begin
        if (!rst) begin
            chk(busy == (mb && !done), "R1 busy vs model", busy, mb && !done);
            if (!fl_we_n) begin
                chk(!fl_ce_n, "R3 ce low with we", fl_ce_n, 0);
                if (we_len == 0) begin
                    cap_a = fl_addr;
                    cap_d = fl_dq_out;
                end else begin
                    chk(fl_addr == cap_a && fl_dq_out == cap_d, "R3 write hold", fl_addr, cap_a);
                end
                we_len++;
            end
            if (fl_we_n && !prev_we) begin
                chk(we_len == SC, "R3 strobe length", we_len, SC);
                chk(fl_addr == cap_a && fl_dq_out == cap_d, "R3 release hold", fl_dq_out, cap_d);
                wr_q.push_back({cap_a, cap_d});
                we_len = 0;
            end
            if (!fl_oe_n && prev_oe)
                chk(fl_addr == '0 && fl_we_n, "R4 poll read addr", fl_addr, 0);
            if (fl_oe_n && !prev_oe) rd_idx++;
            prev_we = fl_we_n;
            prev_oe = fl_oe_n;
        end
    end

    // reference outcome: 0 pass, 1 fail, 2 tmo
    task automatic predict(input int nb, input int q5at, output int res, output int nrd);
        int prev = -1;
        int polls = 0;
        logic [7:0] s, r1, r2;
        res = 2; nrd = 0;
        for (int k = 0; k < 10000; k++) begin
            s = stat(nb, q5at, k);
            if (prev >= 0 && s[7] && (int'(s[6]) == prev)) begin
                res = 0; nrd = k + 1; return;
            end
            if (s[5]) begin
                r1 = stat(nb, q5at, k + 1);
                r2 = stat(nb, q5at, k + 2);
                res = (r1[7] && r2[7] && r1[6] == r2[6]) ? 0 : 1;
                nrd = k + 3; return;
            end
            polls++;
            if (polls == MP) begin
                res = 2; nrd = k + 1; return;
            end
            prev = int'(s[6]);
        end
    endtask

    task automatic run(input string name, input int nb, input int q5at, input bit poke);
        int res, nrd, wbase, n_exp, waited;
        logic [AW+7:0] exp_w[7];
        @(negedge clk);
        sc_busy = nb;
        sc_q5 = q5at;
        rd_base = rd_idx;
        wbase = wr_q.size();
        predict(nb, q5at, res, nrd);
        exp_w[0] = {18'h555, 8'hAA}; exp_w[1] = {18'h2AA, 8'h55};
        exp_w[2] = {18'h555, 8'h80}; exp_w[3] = {18'h555, 8'hAA};
        exp_w[4] = {18'h2AA, 8'h55}; exp_w[5] = {18'h555, 8'h10};
        exp_w[6] = {18'h000, 8'hF0};
        n_exp = (res == 0) ? 6 : 7;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R1 busy after start", busy, 1);
        waited = 0;
        while (!done) begin
            @(negedge clk);
            waited++;
            if (poke && waited == 15) begin
                chk(busy == 1'b1, "R1 busy before ignored start", busy, 1);
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        $display("scenario %s done", name);
        chk(pass == (res == 0), "R5 R6 pass flag", pass, res == 0);
        chk(fail == (res == 1), "R6 fail flag", fail, res == 1);
        chk(tmo == (res == 2), "R7 tmo flag", tmo, res == 2);
        chk(rd_idx - rd_base == nrd, "R5 R6 R7 read count", rd_idx - rd_base, nrd);
        chk(wr_q.size() - wbase == n_exp, "R2 R8 write count", wr_q.size() - wbase, n_exp);
        for (int i = 0; i < n_exp && (wbase + i) < wr_q.size(); i++)
            chk(wr_q[wbase + i] == exp_w[i], i < 6 ? "R2 command write" : "R8 abort write",
                int'(wr_q[wbase + i]), int'(exp_w[i]));
        @(negedge clk);
        chk(!done, "R9 done one cycle", done, 0);
        repeat (3) @(negedge clk);
        chk(pass == (res == 0) && fail == (res == 1) && tmo == (res == 2),
            "R9 flags held", {pass, fail, tmo}, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == LIMIT) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(!busy && !done, "R1 reset idle", {busy, done}, 0);
        chk(!pass && !fail && !tmo, "R9 reset flags", {pass, fail, tmo}, 0);
        chk(fl_ce_n && fl_we_n && fl_oe_n, "R3 reset strobes", {fl_ce_n, fl_we_n, fl_oe_n}, 7);
        run("complete on second ready read", 5, -1, 1'b0);   // R5
        run("complete on first ready read", 4, -1, 1'b0);    // R5
        run("ready at first read", 0, -1, 1'b0);             // R5
        run("q5 then failure", 1000, 3, 1'b0);               // R6 R8
        run("q5 then late finish", 4, 3, 1'b0);              // R6
        run("never finishes", 1000, -1, 1'b0);               // R7 R8
        run("start while busy", 5, -1, 1'b1);                // R1
        run("back to back", 2, -1, 1'b0);                    // R1
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule